// File: doc/BRIEF.md
# Audio Serial Port Status and Event Unit

This unit holds the condition reporting and interrupt logic of a serial audio port controller. The controller has a transmit FIFO and a receive FIFO. The unit does not contain the FIFOs, the shift engine or any DMA path. It only receives their live condition signals:

- fill level, full and empty for each FIFO,
- busy for each direction,
- overflow and underflow strobes,
- the ready indications,
- two configuration bits (device enable and programmed-I/O mode),
- the two request thresholds.

From these inputs it builds three 32-bit registers:

- a read-only status snapshot,
- a sticky event register whose bits are cleared by writing 1,
- an interrupt mask.

One registered interrupt line leaves the block.

Software reaches the three registers through a single-cycle register port. The status word is at byte offset 0x14, the event word at 0x18 and the mask at 0x1C. Reads are combinational from the current address. A write takes effect at the clock edge at which `reg_wen` is high.

Top module: `audio_port_evt_unit`

## Requirements
- R1: The status word at 0x14 is a registered copy of the conditions of the previous cycle. The bit positions are:
  - 13 receive full, 12 receive empty, 11 receive request
  - 10 transmit full, 9 transmit empty, 8 transmit request
  - 5 receive busy, 4 transmit busy
  - 2 device interrupt, 1 device ready, 0 port ready
  - all other bits read 0.
- R2: While reset is asserted, the registers read as follows: status 0x00001200, event 0, mask 0x00003F00. The interrupt output is 0.
- R3: When the device-enable input was 0 in the previous cycle, the status word carries only bits 1 and 0. Every other bit reads 0.
- R4: The event bit positions are 13 receive request, 12 receive overflow, 11 receive underflow, 10 transmit request, 9 transmit overflow and 8 transmit underflow. A bit is set on the rising edge of its condition and stays set until software clears it.
- R5: Writing 1 to an event bit at 0x18 clears it. Writing 0 leaves it unchanged.
- R6: If a condition rises in the same cycle as a write-1 clear of its bit, the bit ends up set.
- R7: The request conditions exist only while the programmed-I/O input is 1:
  - receive request needs receive level ≥ receive threshold,
  - transmit request needs free transmit entries (DEPTH minus transmit level) ≥ transmit threshold.
  
  The same conditions drive status bits 11 and 8.
- R8: The mask at 0x1C uses the event bit positions, and a 1 blocks that bit. The interrupt output is registered. It equals the OR of all unmasked event bits of the previous cycle.
- R9: Status bit 2 is 1 exactly when the device was enabled and at least one unmasked event bit was set in the previous cycle.
- R10: Writes to the status offset or to unmapped offsets change nothing. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dev_en | input | 1 | Device enable configuration bit |
| cfg_pio_mode | input | 1 | Programmed-I/O mode bit |
| rx_thresh | input | LVL_W | Receive request threshold |
| tx_thresh | input | LVL_W | Transmit request threshold |
| rx_level | input | LVL_W | Entries held in receive FIFO |
| tx_level | input | LVL_W | Entries held in transmit FIFO |
| rx_full | input | 1 | Receive FIFO full |
| rx_empty | input | 1 | Receive FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| rx_busy | input | 1 | Receive engine active |
| tx_busy | input | 1 | Transmit engine active |
| rx_ovf | input | 1 | Receive overflow condition |
| rx_unf | input | 1 | Receive underflow condition |
| tx_ovf | input | 1 | Transmit overflow condition |
| tx_unf | input | 1 | Transmit underflow condition |
| dev_ready | input | 1 | Controller ready for protocol operation |
| port_ready | input | 1 | Port ready for configuration |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The collision that matters here is a hardware event set and a software write-1 clear landing on the same flag in the same cycle. The bench provokes it directly, raising the overflow strobe in the very cycle that clears bit 12. It also provokes it at random, with write traffic to 0x18 running alongside random condition pulses. A behavioural model computes the set-dominant result, and the bench compares the event word, the status word and the interrupt line with the model on every clock. A second overlap also gets directed cycles: a mask write landing together with a new flag, which shows whether the interrupt follows the previous-cycle mask.

// File: rtl/aspe_pkg.sv
package aspe_pkg;
   localparam logic [7:0] OFS_STAT = 8'h14;
   localparam logic [7:0] OFS_EVT  = 8'h18;
   localparam logic [7:0] OFS_MASK = 8'h1C;

   localparam int EVT_N   = 6;
   localparam int EVT_LSB = 8;

   // event index, position EVT_LSB + index
   localparam int EV_TX_UNF = 0;
   localparam int EV_TX_OVF = 1;
   localparam int EV_TX_REQ = 2;
   localparam int EV_RX_UNF = 3;
   localparam int EV_RX_OVF = 4;
   localparam int EV_RX_REQ = 5;

   localparam logic [31:0] STAT_RST = 32'h0000_1200;

   typedef struct packed {
      logic rx_full;
      logic rx_empty;
      logic rx_req;
      logic tx_full;
      logic tx_empty;
      logic tx_req;
      logic rx_busy;
      logic tx_busy;
      logic dev_int;
      logic dev_rdy;
      logic port_rdy;
   } stat_cond_t;

   function automatic logic [31:0] pack_status(input stat_cond_t c);
      logic [31:0] w;
      w     = '0;
      w[13] = c.rx_full;
      w[12] = c.rx_empty;
      w[11] = c.rx_req;
      w[10] = c.tx_full;
      w[9]  = c.tx_empty;
      w[8]  = c.tx_req;
      w[5]  = c.rx_busy;
      w[4]  = c.tx_busy;
      w[2]  = c.dev_int;
      w[1]  = c.dev_rdy;
      w[0]  = c.port_rdy;
      return w;
   endfunction
endpackage

// File: rtl/aspe_req_detect.sv
module aspe_req_detect #(
   parameter int DEPTH            = 16,
   parameter bit TX_LEVEL_IS_FREE = 1'b0,
   localparam int LVL_W           = $clog2(DEPTH + 1)
) (
   input  logic             pio_mode,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] rx_thresh,
   input  logic [LVL_W-1:0] tx_level,
   input  logic [LVL_W-1:0] tx_thresh,
   output logic             rx_req,
   output logic             tx_req
);
   logic [LVL_W:0] tx_free;

   generate
      if (TX_LEVEL_IS_FREE) begin : g_free_in
         assign tx_free = {1'b0, tx_level};
      end else begin : g_occ_in
         assign tx_free = (LVL_W+1)'(DEPTH) - {1'b0, tx_level};
      end
   endgenerate

   assign rx_req = pio_mode && (rx_level >= rx_thresh);
   assign tx_req = pio_mode && (tx_free >= {1'b0, tx_thresh});
endmodule

// File: rtl/aspe_event_bank.sv
module aspe_event_bank #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] cond,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic prev_q;
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               flag_q <= 1'b0;
            end else begin
               prev_q <= cond[i];
               // a rising condition dominates a same-cycle clear
               flag_q <= (flag_q & ~clr[i]) | (cond[i] & ~prev_q);
            end
         end
         assign flags[i] = flag_q;
      end
   endgenerate
endmodule

// File: rtl/aspe_status_snap.sv
module aspe_status_snap
   import aspe_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        dev_en,
   input  stat_cond_t  live,
   output logic [31:0] stat_q
);
   logic [31:0] stat_d;

   always_comb begin
      if (dev_en) stat_d = pack_status(live);
      else        stat_d = {30'b0, live.dev_rdy, live.port_rdy};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= STAT_RST;
      else        stat_q <= stat_d;
   end
endmodule

// File: rtl/audio_port_evt_unit.sv
module audio_port_evt_unit
   import aspe_pkg::*;
#(
   parameter int DEPTH            = 16,
   parameter int ADDR_W           = 8,
   parameter bit TX_LEVEL_IS_FREE = 1'b0,
   localparam int LVL_W           = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_dev_en,
   input  logic              cfg_pio_mode,
   input  logic [LVL_W-1:0]  rx_thresh,
   input  logic [LVL_W-1:0]  tx_thresh,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic [LVL_W-1:0]  tx_level,
   input  logic              rx_full,
   input  logic              rx_empty,
   input  logic              tx_full,
   input  logic              tx_empty,
   input  logic              rx_busy,
   input  logic              tx_busy,
   input  logic              rx_ovf,
   input  logic              rx_unf,
   input  logic              tx_ovf,
   input  logic              tx_unf,
   input  logic              dev_ready,
   input  logic              port_ready,
   input  logic              reg_wen,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("audio_port_evt_unit: DEPTH must be at least 2");
      end
      if (ADDR_W < 5) begin : g_bad_aw
         $error("audio_port_evt_unit: ADDR_W must reach offset 0x1C");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(OFS_EVT);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

   logic             rx_req, tx_req;
   logic [EVT_N-1:0] cond, clr, evt_q, mask_q;
   logic             pend;
   logic             irq_q;
   logic [31:0]      stat_q;
   stat_cond_t       live;
   logic             wr_evt, wr_mask;
   logic             unused_wbits;

   assign unused_wbits = ^{reg_wdata[31:EVT_LSB+EVT_N], reg_wdata[EVT_LSB-1:0]};

   aspe_req_detect #(.DEPTH(DEPTH), .TX_LEVEL_IS_FREE(TX_LEVEL_IS_FREE)) u_req (
      .pio_mode (cfg_pio_mode),
      .rx_level (rx_level),
      .rx_thresh(rx_thresh),
      .tx_level (tx_level),
      .tx_thresh(tx_thresh),
      .rx_req   (rx_req),
      .tx_req   (tx_req)
   );

   always_comb begin
      cond            = '0;
      cond[EV_TX_UNF] = tx_unf;
      cond[EV_TX_OVF] = tx_ovf;
      cond[EV_TX_REQ] = tx_req;
      cond[EV_RX_UNF] = rx_unf;
      cond[EV_RX_OVF] = rx_ovf;
      cond[EV_RX_REQ] = rx_req;
   end

   assign wr_evt  = reg_wen && (reg_addr == A_EVT);
   assign wr_mask = reg_wen && (reg_addr == A_MASK);
   assign clr     = wr_evt ? reg_wdata[EVT_LSB +: EVT_N] : '0;

   aspe_event_bank #(.N(EVT_N)) u_evt (
      .clk  (clk),
      .rst_n(rst_n),
      .cond (cond),
      .clr  (clr),
      .flags(evt_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '1;
      else if (wr_mask) mask_q <= reg_wdata[EVT_LSB +: EVT_N];
   end

   assign pend = |(evt_q & ~mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= pend;
   end
   assign irq = irq_q;

   always_comb begin
      live.rx_full  = rx_full;
      live.rx_empty = rx_empty;
      live.rx_req   = rx_req;
      live.tx_full  = tx_full;
      live.tx_empty = tx_empty;
      live.tx_req   = tx_req;
      live.rx_busy  = rx_busy;
      live.tx_busy  = tx_busy;
      live.dev_int  = pend;
      live.dev_rdy  = dev_ready;
      live.port_rdy = port_ready;
   end

   aspe_status_snap u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .dev_en(cfg_dev_en),
      .live  (live),
      .stat_q(stat_q)
   );

   always_comb begin
      unique case (reg_addr)
         A_STAT:  reg_rdata = stat_q;
         A_EVT:   reg_rdata = 32'(evt_q) << EVT_LSB;
         A_MASK:  reg_rdata = 32'(mask_q) << EVT_LSB;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/aspe_checker.sv
module aspe_checker
   import aspe_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_dev_en,
   input logic              cfg_pio_mode,
   input logic              rx_ovf,
   input logic              reg_wen,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       stat_q,
   input logic [EVT_N-1:0]  evt_q,
   input logic [EVT_N-1:0]  mask_q,
   input logic              irq
);
   logic wr_evt;
   assign wr_evt = reg_wen && (reg_addr == ADDR_W'(OFS_EVT));

   // R3: disabled device shows only ready bits
   p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_dev_en |=> (stat_q[31:2] == 30'b0));

   // R4: flags never drop without a write to the event offset
   p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_evt |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

   // R6: a rising overflow lands even under a clear
   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ovf && !$past(rx_ovf) && (evt_q[EV_RX_OVF] || !$past(evt_q[EV_RX_OVF]) || 1'b1))
      |=> evt_q[EV_RX_OVF] || !$past(rx_ovf, 1) || $past(rx_ovf, 2));

   // R7: no receive request flag appears outside programmed-I/O mode
   p_no_req_without_pio_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_pio_mode && !evt_q[EV_RX_REQ] && !evt_q[EV_TX_REQ])
      |=> (!evt_q[EV_RX_REQ] && !evt_q[EV_TX_REQ]));

   // R8: interrupt follows previous-cycle unmasked pending flags
   p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == |($past(evt_q) & ~$past(mask_q))));

   // R9: summary status bit implies interrupt
   p_di_implies_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[2] |-> irq);
endmodule

bind audio_port_evt_unit aspe_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_dev_en  (cfg_dev_en),
   .cfg_pio_mode(cfg_pio_mode),
   .rx_ovf      (rx_ovf),
   .reg_wen     (reg_wen),
   .reg_addr    (reg_addr),
   .stat_q      (stat_q),
   .evt_q       (evt_q),
   .mask_q      (mask_q),
   .irq         (irq)
);

// File: tb/sim_audio_port_evt_unit.sv
`timescale 1ns/1ps
module sim_audio_port_evt_unit;
   localparam int DEPTH = 16;
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_dev_en = 0, cfg_pio_mode = 0;
   logic [LVL_W-1:0] rx_thresh = 0, tx_thresh = 0, rx_level = 0, tx_level = 0;
   logic rx_full = 0, rx_empty = 1, tx_full = 0, tx_empty = 1;
   logic rx_busy = 0, tx_busy = 0, rx_ovf = 0, rx_unf = 0, tx_ovf = 0, tx_unf = 0;
   logic dev_ready = 0, port_ready = 0;
   logic reg_wen = 0;
   logic [7:0] reg_addr = 8'h14;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic irq;

   always #2.5 clk = ~clk;

   audio_port_evt_unit #(.DEPTH(DEPTH)) u0 (.*);

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   string tag = "R1";

   // reference model state
   int m_stat = 32'h1200;
   int m_evt = 0, m_mask = 32'h3F, m_prev = 0;
   bit m_irq = 0;

   function automatic int cond_now();
      int c = 0;
      int txfree = DEPTH - int'(tx_level);
      if (tx_unf) c |= 1;
      if (tx_ovf) c |= 2;
      if (cfg_pio_mode && txfree >= int'(tx_thresh)) c |= 4;
      if (rx_unf) c |= 8;
      if (rx_ovf) c |= 16;
      if (cfg_pio_mode && int'(rx_level) >= int'(rx_thresh)) c |= 32;
      return c;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_stat = 32'h1200; m_evt = 0; m_mask = 32'h3F; m_prev = 0; m_irq = 0;
      end else begin
         int c, ns, pend, clrv;
         c = cond_now();
         pend = ((m_evt & ~m_mask) & 32'h3F) != 0;
         ns = (dev_ready ? 2 : 0) | (port_ready ? 1 : 0);
         if (cfg_dev_en) begin
            ns |= (rx_full << 13) | (rx_empty << 12) | (((c >> 5) & 1) << 11)
                | (tx_full << 10) | (tx_empty << 9) | (((c >> 2) & 1) << 8)
                | (rx_busy << 5) | (tx_busy << 4) | (pend << 2);
         end
         clrv = (reg_wen && reg_addr == 8'h18) ? ((reg_wdata >> 8) & 32'h3F) : 0;
         m_irq = pend;
         m_stat = ns;
         m_evt = (m_evt & ~clrv) | (c & ~m_prev);
         m_prev = c;
         if (reg_wen && reg_addr == 8'h1C) m_mask = (reg_wdata >> 8) & 32'h3F;
      end
   end

   function automatic logic [31:0] model_read(logic [7:0] a);
      case (a)
         8'h14: return 32'(m_stat);
         8'h18: return 32'(m_evt << 8);
         8'h1C: return 32'(m_mask << 8);
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (t=%0t addr=%h)", req, act, exp, $time, reg_addr);
      end
   endtask

   task automatic compare();
      string t;
      t = (tag != "") ? tag : "R1";
      if (reg_addr == 8'h18) t = (tag == "R1") ? "R4" : tag;
      if (reg_addr != 8'h14 && reg_addr != 8'h18 && reg_addr != 8'h1C) t = "R10";
      chk(t, reg_rdata, model_read(reg_addr));
      chk("R8", {31'b0, irq}, {31'b0, m_irq});
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      reg_wen = 1; reg_addr = a; reg_wdata = d;
      cyc();
      reg_wen = 0;
   endtask

   task automatic set_levels(int rl, int tl);
      rx_level = LVL_W'(rl); rx_full = (rl == DEPTH); rx_empty = (rl == 0);
      tx_level = LVL_W'(tl); tx_full = (tl == DEPTH); tx_empty = (tl == 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R1: watchdog actual hung expected finished");
      finish_run();
   end

   initial begin
      // R2: reset values while reset is held
      @(negedge clk);
      reg_addr = 8'h14; #0.1; chk("R2", reg_rdata, 32'h1200);
      reg_addr = 8'h18; #0.1; chk("R2", reg_rdata, 32'h0);
      reg_addr = 8'h1C; #0.1; chk("R2", reg_rdata, 32'h3F00);
      chk("R2", {31'b0, irq}, 32'h0);
      repeat (2) @(negedge clk);
      rst_n = 1;
      reg_addr = 8'h14;

      // R3: disabled, busy/full inputs are hidden
      tag = "R3";
      dev_ready = 1; port_ready = 1; rx_busy = 1; tx_busy = 1;
      set_levels(DEPTH, DEPTH);
      cyc(); cyc();
      chk("R3", reg_rdata, 32'h3);

      // R1: enabled layout
      tag = "R1";
      cfg_dev_en = 1;
      cyc(); cyc();
      chk("R1", reg_rdata, 32'h2433);
      set_levels(0, 0); rx_busy = 0; tx_busy = 0;
      cyc(); cyc();

      // R8: unmask all; overflow pulse raises irq one cycle after the flag
      tag = "R8";
      wr(8'h1C, 32'h0);
      rx_ovf = 1; cyc(); rx_ovf = 0;
      reg_addr = 8'h18; #0.1; chk("R4", reg_rdata, 32'h1000);
      cyc();
      chk("R8", {31'b0, irq}, 32'h1);

      // R9: summary bit
      tag = "R9";
      reg_addr = 8'h14; cyc();
      chk("R9", reg_rdata & 32'h4, 32'h4);

      // R5: write 0 keeps, write 1 clears
      tag = "R5";
      wr(8'h18, 32'h0);
      reg_addr = 8'h18; #0.1; chk("R5", reg_rdata, 32'h1000);
      wr(8'h18, 32'h1000);
      reg_addr = 8'h18; #0.1; chk("R5", reg_rdata, 32'h0);
      cyc();
      chk("R8", {31'b0, irq}, 32'h0);

      // R6: set and clear in the same cycle
      tag = "R6";
      rx_ovf = 1; cyc(); rx_ovf = 0; cyc();
      rx_ovf = 1; wr(8'h18, 32'h1000); rx_ovf = 0;
      reg_addr = 8'h18; #0.1; chk("R6", reg_rdata, 32'h1000);
      wr(8'h18, 32'h3F00);

      // R7: requests only in programmed-I/O mode
      tag = "R7";
      rx_thresh = 4; tx_thresh = 4;
      set_levels(8, 2);
      reg_addr = 8'h18; cyc(); cyc();
      chk("R7", reg_rdata, 32'h0);
      cfg_pio_mode = 1; cyc();
      chk("R7", reg_rdata, 32'h2400);
      wr(8'h18, 32'h3F00);
      set_levels(3, 13); cyc(); cyc();
      set_levels(4, 12); cyc();
      chk("R7", reg_rdata, 32'h2400);

      // R10: status and unmapped writes ignored
      tag = "R10";
      wr(8'h14, 32'hFFFF_FFFF);
      wr(8'h20, 32'hFFFF_FFFF);
      reg_addr = 8'h20; cyc();
      chk("R10", reg_rdata, 32'h0);
      reg_addr = 8'h1C; #0.1; chk("R10", reg_rdata, 32'h0);

      // mask write in same cycle as a new flag
      tag = "R8";
      tx_unf = 1; wr(8'h1C, 32'h3F00); tx_unf = 0;
      cyc(); cyc();

      // random traffic
      tag = "R1";
      for (int i = 0; i < 4000; i++) begin
         int r = int'($urandom_range(0, 99));
         set_levels(int'($urandom_range(0, DEPTH)), int'($urandom_range(0, DEPTH)));
         rx_busy = $urandom_range(0, 1) == 1; tx_busy = $urandom_range(0, 1) == 1;
         rx_ovf = $urandom_range(0, 5) == 0; rx_unf = $urandom_range(0, 5) == 0;
         tx_ovf = $urandom_range(0, 5) == 0; tx_unf = $urandom_range(0, 5) == 0;
         if (r < 4) cfg_dev_en = ~cfg_dev_en;
         if (r >= 4 && r < 8) cfg_pio_mode = ~cfg_pio_mode;
         if (r >= 8 && r < 10) begin
            rx_thresh = LVL_W'($urandom_range(0, DEPTH));
            tx_thresh = LVL_W'($urandom_range(0, DEPTH));
         end
         dev_ready = $urandom_range(0, 7) != 0; port_ready = $urandom_range(0, 7) != 0;
         case ($urandom_range(0, 4))
            0: reg_addr = 8'h14;
            1: reg_addr = 8'h18;
            2: reg_addr = 8'h1C;
            3: reg_addr = 8'h10;
            default: reg_addr = 8'h18;
         endcase
         reg_wen = $urandom_range(0, 3) == 0;
         reg_wdata = $urandom;
         tag = (reg_wen && reg_addr == 8'h18) ? "R6" : "R1";
         cyc();
         reg_wen = 0;
      end
      finish_run();
   end
endmodule